// File: doc/BRIEF.md
# UART Receive Line Status Logic

This block sits between the receive shift register of a UART and the software-visible receive path. Each time the deserializer finishes a character, it pulses `char_valid`. The strobe carries the data byte and the result of the parity check on that character. The block queues the character in a receive FIFO, shows the oldest unread character on `head_data`, and keeps a three-bit read-only line status word with data-ready, overrun and parity-error flags.

A data read (`fifo_rd`) removes the head character. A status read (`lsr_rd`) clears the two error flags. When the FIFO is full, the stored characters are kept and the new character is lost, which raises the overrun flag. Every queued character carries its own parity-error tag. The parity flag is raised when a tagged character becomes the head of the queue, so the flag always describes the character that software is about to read.

Top module: `uart_rx_linestat`

## Requirements
- R1: Status bit 0 (data ready) is 1 exactly when the FIFO holds one or more unread characters. It follows the clock edge that stores or removes a character.
- R2: Characters stored by `char_valid` leave on `head_data` in arrival order. Each `fifo_rd` on a non-empty FIFO removes the head at the next edge.
- R3: A character that arrives while the FIFO holds DEPTH (default 16) entries, with no `fifo_rd` in that cycle, sets status bit 1 (overrun) at that edge. The character is discarded and the stored entries and `head_data` are unchanged.
- R4: A character that arrives at a full FIFO in the same cycle as a `fifo_rd` is accepted, and no overrun is raised.
- R5: Status bit 2 (parity error) becomes 1 one clock after a character tagged with a parity error first appears at the FIFO head. Untagged characters never set it, and a tagged character further back in the queue does not set it.
- R6: An `lsr_rd` clears status bits 1 and 2 at the next edge. `fifo_rd` leaves both bits unchanged.
- R7: When an overrun or parity event falls in the same cycle as an `lsr_rd`, the flag is set rather than cleared.
- R8: A `fifo_rd` on an empty FIFO changes no state. `head_data` keeps the last head character (0 if none was ever read).
- R9: After reset, the status word is 000 and `head_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| char_valid | input | 1 | One-cycle strobe: a character has been assembled |
| char_data | input | DATA_W | Assembled character |
| char_perr | input | 1 | Parity check of the assembled character failed |
| fifo_rd | input | 1 | Read and remove the head character |
| lsr_rd | input | 1 | Status read; clears the error flags |
| head_data | output | DATA_W | Character at the FIFO head |
| lsr_status | output | 3 | {parity error, overrun, data ready} |

## Verification
Two pairs of operations can fall in the same cycle. The first is a status-read clear together with a setting event (an overrun, or a tagged character reaching the head). The second is a character arriving at a full FIFO together with a data read. Directed steps force each collision once: the FIFO is filled to 16 entries, and then the arrival is paired with `lsr_rd` or with `fifo_rd`. Random traffic with a high strobe density produces many more collisions. Each outcome is judged against a queue model in the bench, which applies the set-over-clear rule and the accept-on-read rule, and against bound properties on the flag transitions.

// File: rtl/rxls_pkg.sv
package rxls_pkg;
   localparam int LSR_W   = 3;
   localparam int LSR_DR  = 0;
   localparam int LSR_OE  = 1;
   localparam int LSR_PE  = 2;
   localparam int N_ERR   = 2;
   localparam int ERR_OE  = 0;
   localparam int ERR_PE  = 1;
endpackage

// File: rtl/rxls_sticky.sv
module rxls_sticky (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   // set has priority over clear so a same-cycle event survives a read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flag_o <= 1'b0;
      else if (set_i)
         flag_o <= 1'b1;
      else if (clr_i)
         flag_o <= 1'b0;
   end
endmodule

// File: rtl/rxls_fifo.sv
module rxls_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              wr_tag_i,
   input  logic              rd_i,
   output logic [DATA_W-1:0] head_data_o,
   output logic              head_tag_o,
   output logic              empty_o,
   output logic              full_o,
   output logic              fresh_o,
   output logic              drop_o
);
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = $clog2(DEPTH + 1);
   localparam int EW   = DATA_W + 1;
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   if (DEPTH < 2) begin : g_bad_depth
      $error("rxls_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("rxls_fifo: DATA_W must be positive");
   end

   logic [EW-1:0]     mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]     count;
   logic [DATA_W-1:0] last_q;
   logic              pop, push, new_head, fresh_q;

   // pointer advance: free wrap for power-of-two depths, compare otherwise
   if (POW2) begin : g_wrap_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign empty_o = (count == '0);
   assign full_o  = (count == CW'(DEPTH));
   assign pop     = rd_i & ~empty_o;
   assign push    = wr_i & (~full_o | pop);
   assign drop_o  = wr_i & ~push;

   // a different entry becomes head after this edge
   assign new_head = (push & empty_o) |
                     (pop & ((count > CW'(1)) | push));

   always_ff @(posedge clk) begin
      if (push)
         mem[wr_ptr] <= {wr_tag_i, wr_data_i};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         last_q  <= '0;
         fresh_q <= 1'b0;
      end else begin
         if (push)
            wr_ptr <= wr_nxt;
         if (pop) begin
            rd_ptr <= rd_nxt;
            last_q <= mem[rd_ptr][DATA_W-1:0];
         end
         if (push & ~pop)
            count <= count + 1'b1;
         else if (pop & ~push)
            count <= count - 1'b1;
         fresh_q <= new_head;
      end
   end

   assign head_data_o = empty_o ? last_q : mem[rd_ptr][DATA_W-1:0];
   assign head_tag_o  = ~empty_o & mem[rd_ptr][DATA_W];
   assign fresh_o     = fresh_q;
endmodule

// File: rtl/uart_rx_linestat.sv
module uart_rx_linestat #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     char_valid,
   input  logic [DATA_W-1:0]        char_data,
   input  logic                     char_perr,
   input  logic                     fifo_rd,
   input  logic                     lsr_rd,
   output logic [DATA_W-1:0]        head_data,
   output logic [rxls_pkg::LSR_W-1:0] lsr_status
);
   import rxls_pkg::*;

   logic             fifo_empty, fifo_full, head_tag, head_fresh, drop;
   logic             ovr_evt, pe_evt;
   logic [N_ERR-1:0] err_set, err_flag;

   rxls_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_i        (char_valid),
      .wr_data_i   (char_data),
      .wr_tag_i    (char_perr),
      .rd_i        (fifo_rd),
      .head_data_o (head_data),
      .head_tag_o  (head_tag),
      .empty_o     (fifo_empty),
      .full_o      (fifo_full),
      .fresh_o     (head_fresh),
      .drop_o      (drop)
   );

   assign ovr_evt = drop;
   assign pe_evt  = head_fresh & head_tag;

   assign err_set[ERR_OE] = ovr_evt;
   assign err_set[ERR_PE] = pe_evt;

   for (genvar i = 0; i < N_ERR; i++) begin : g_err
      rxls_sticky u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (err_set[i]),
         .clr_i  (lsr_rd),
         .flag_o (err_flag[i])
      );
   end

   always_comb begin
      lsr_status         = '0;
      lsr_status[LSR_DR] = ~fifo_empty;
      lsr_status[LSR_OE] = err_flag[ERR_OE];
      lsr_status[LSR_PE] = err_flag[ERR_PE];
   end
endmodule

// File: rtl/rxls_chk.sv
module rxls_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              char_valid,
   input logic              fifo_rd,
   input logic              lsr_rd,
   input logic [2:0]        lsr_status,
   input logic [DATA_W-1:0] head_data,
   input logic              fifo_full,
   input logic              pe_evt
);
   logic ovr_case;
   assign ovr_case = char_valid & fifo_full & ~fifo_rd;

   p_arrival_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
      char_valid |=> lsr_status[0]);

   p_idle_stays_empty_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!lsr_status[0] && !char_valid) |=> !lsr_status[0]);

   p_overrun_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_case |=> lsr_status[1]);

   p_overrun_keeps_head_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_case |=> $stable(head_data));

   p_full_read_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (char_valid && fifo_full && fifo_rd && !lsr_status[1]) |=> !lsr_status[1]);

   p_parity_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pe_evt |=> lsr_status[2]);

   p_read_clears_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !ovr_case) |=> !lsr_status[1]);

   p_read_clears_pe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && !pe_evt) |=> !lsr_status[2]);

   p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (lsr_rd && ovr_case) |=> lsr_status[1]);

   p_empty_read_inert_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!lsr_status[0] && fifo_rd && !char_valid) |=> ($stable(head_data) && !lsr_status[0]));
endmodule

bind uart_rx_linestat rxls_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .char_valid (char_valid),
   .fifo_rd    (fifo_rd),
   .lsr_rd     (lsr_rd),
   .lsr_status (lsr_status),
   .head_data  (head_data),
   .fifo_full  (fifo_full),
   .pe_evt     (pe_evt)
);

// File: tb/uart_rx_linestat_tb.sv
`timescale 1ns/1ps
module uart_rx_linestat_tb;
   localparam int DATA_W = 8;
   localparam int DEPTH  = 16;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              char_valid = 1'b0;
   logic [DATA_W-1:0] char_data = '0;
   logic              char_perr = 1'b0;
   logic              fifo_rd = 1'b0;
   logic              lsr_rd = 1'b0;
   logic [DATA_W-1:0] head_data;
   logic [2:0]        lsr_status;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [DATA_W:0]   q [$];
   bit                m_oe, m_pe, m_fresh;
   logic [DATA_W-1:0] m_last;

   always #2.5 clk = ~clk;

   uart_rx_linestat #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .char_valid (char_valid),
      .char_data  (char_data),
      .char_perr  (char_perr),
      .fifo_rd    (fifo_rd),
      .lsr_rd     (lsr_rd),
      .head_data  (head_data),
      .lsr_status (lsr_status)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic logic [DATA_W-1:0] exp_head();
      logic [DATA_W:0] e;
      if (q.size() == 0) return m_last;
      e = q[0];
      return e[DATA_W-1:0];
   endfunction

   task automatic step(input bit cv, input logic [DATA_W-1:0] cd, input bit cp,
                       input bit frd, input bit lrd, input string tag);
      bit full, pop, acc, ovr, nh, pe_set;
      int sz;
      logic [DATA_W:0] h;
      @(negedge clk);
      char_valid = cv; char_data = cd; char_perr = cp;
      fifo_rd = frd; lsr_rd = lrd;
      @(posedge clk);
      sz   = q.size();
      full = (sz == DEPTH);
      pop  = frd && (sz > 0);
      acc  = cv && (!full || pop);
      ovr  = cv && !acc;
      nh   = (acc && sz == 0) || (pop && (sz > 1 || acc));
      h    = (sz > 0) ? q[0] : '0;
      pe_set = m_fresh && (sz > 0) && h[DATA_W];
      if (pop) begin
         m_last = h[DATA_W-1:0];
         void'(q.pop_front());
      end
      if (acc) q.push_back({cp, cd});
      m_oe    = ovr    | (m_oe & ~lrd);
      m_pe    = pe_set | (m_pe & ~lrd);
      m_fresh = nh;
      #1;
      chk(tag, "data-ready", int'(lsr_status[0]), int'(q.size() > 0));
      chk(tag, "overrun",    int'(lsr_status[1]), int'(m_oe));
      chk(tag, "parity",     int'(lsr_status[2]), int'(m_pe));
      chk(tag, "head",       int'(head_data),     int'(exp_head()));
      char_valid = 1'b0; fifo_rd = 1'b0; lsr_rd = 1'b0; char_perr = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      void'($urandom(32'd2741));
      m_oe = 0; m_pe = 0; m_fresh = 0; m_last = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state
      chk("R9", "status", int'(lsr_status), 0);
      chk("R9", "head",   int'(head_data),  0);

      // R8: read of an empty FIFO
      step(0, 8'h00, 0, 1, 0, "R8");

      // R2: order of delivery
      step(1, 8'h11, 0, 0, 0, "R2");
      step(1, 8'h22, 0, 0, 0, "R2");
      step(1, 8'h33, 0, 0, 0, "R2");
      for (int i = 0; i < 3; i++) step(0, 8'h00, 0, 1, 0, "R2");
      step(0, 8'h00, 0, 1, 0, "R8");

      // R1: fill to DEPTH
      for (int i = 0; i < DEPTH; i++) step(1, 8'(8'h40 + i), 0, 0, 0, "R1");
      // R3: overrun discards the new character
      step(1, 8'hEE, 1, 0, 0, "R3");
      step(0, 8'h00, 0, 0, 0, "R3");
      // R6: data read leaves flag, status read clears it
      step(0, 8'h00, 0, 1, 0, "R6");
      step(1, 8'h50, 0, 0, 0, "R6");
      step(0, 8'h00, 0, 0, 1, "R6");
      // R4: arrival at full FIFO with a data read
      step(1, 8'h5A, 0, 1, 0, "R4");
      // R7: overrun in the same cycle as a status read
      step(1, 8'hA5, 0, 0, 1, "R7");
      step(0, 8'h00, 0, 0, 1, "R6");
      for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 0, 1, 0, "R8");
      step(0, 8'h00, 0, 1, 0, "R8");

      // R5: tagged character behind a clean one
      step(1, 8'h61, 0, 0, 0, "R5");
      step(1, 8'h62, 1, 0, 0, "R5");
      step(0, 8'h00, 0, 0, 0, "R5");
      step(0, 8'h00, 0, 1, 0, "R5");
      step(0, 8'h00, 0, 0, 0, "R5");
      step(0, 8'h00, 0, 0, 1, "R6");
      // R7: parity event collides with a status read
      step(1, 8'h63, 1, 1, 0, "R7");
      step(0, 8'h00, 0, 0, 1, "R7");
      step(0, 8'h00, 0, 0, 1, "R6");
      step(0, 8'h00, 0, 1, 0, "R8");

      // random traffic
      for (int i = 0; i < 4000; i++) begin
         bit cv, cp, frd, lrd;
         cv  = ($urandom % 100) < 55;
         cp  = ($urandom % 100) < 20;
         frd = ($urandom % 100) < 40;
         lrd = ($urandom % 100) < 15;
         step(cv, 8'($urandom), cp, frd, lrd, "R2");
      end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end
endmodule